// File: doc/BRIEF.md
# LCD Drive Polarity Generator

This block produces the alternating-polarity signal that an LCD panel driver uses to reverse pixel drive from time to time. Regular reversals keep the average voltage across each pixel at zero. The phase flips on one of two events, and a configuration register chooses which. In frame mode the phase inverts once on every frame-start strobe. In line mode the phase inverts each time a programmed number of line strobes has been counted. The line counter runs freely across frame boundaries.

The block sits beside the display timing generator, which supplies the line and frame strobes. The block only reacts to those strobes, together with writes to its 8-bit configuration register. Besides the polarity level it gives a one-cycle flip pulse on every polarity change, so that the drive balance can be watched from outside.

An odd number of flips per frame makes each line's polarity alternate between successive frames. For example, 240 lines with a count of 16 gives 15 flips per frame. An even number of flips per frame, as with counts of 2, 4 or 8, repeats the same polarity map in every frame.

Top module: `lcd_polarity_gen`

## Requirements
- R1: After reset `pol_o` is 0, `flip_o` is 0 and `cfg_rdata_o` reads 0x80, which is frame mode with a count of 0.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i`, and the stored value appears on `cfg_rdata_o` from the following cycle.
- R3: With configuration bit 7 at 1 (frame mode), each cycle with `frame_stb_i` high inverts `pol_o` once. `line_stb_i` has no effect on `pol_o` in this mode.
- R4: With configuration bit 7 at 0 (line mode), `pol_o` inverts on every N-th `line_stb_i`, where N is configuration bits 6:0.
- R5: In line mode a count field of 0 means N = 128.
- R6: In line mode `frame_stb_i` neither inverts `pol_o` nor clears the line counter. A cycle with both strobes high inverts `pol_o` at most once.
- R7: A configuration write clears the line counter and leaves `pol_o` unchanged. A line strobe in the same cycle as a write is not counted.
- R8: `pol_o` and `flip_o` are registered. Both update on the clock edge that samples the causing strobe. `flip_o` is high for exactly one cycle after each change of `pol_o` and is low otherwise.
- R9: In line mode with N = 16 and 240 line strobes per frame, each line's polarity differs between two consecutive frames, and the line periods spent high and low over those two frames are equal. With N = 8, each line has the same polarity in both frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_stb_i | input | 1 | One-cycle line pulse strobe |
| frame_stb_i | input | 1 | One-cycle frame start strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 8 | Configuration write data: bit 7 selects frame mode, bits 6:0 hold the line count |
| cfg_rdata_o | output | 8 | Configuration readback |
| pol_o | output | 1 | Drive polarity level |
| flip_o | output | 1 | One-cycle pulse on each polarity change |

## Verification
A wrong line counter value shows at the ports as a polarity flip on the wrong line strobe. This appears within one count period of the fault, so the bench counts strobes and checks both the strobe just before the expected flip and the strobe that should flip. A mode decode error or a missing counter clear shows on the first strobe after the configuration write. A count that drifts slowly only becomes visible over long runs, so the bench runs two full 240-line frames and compares each line's polarity between the frames. A stuck or doubled flip pulse appears in the cycle right after the causing strobe.

// File: rtl/lcd_pol_pkg.sv
package lcd_pol_pkg;
  typedef enum logic {
    MODE_LINE  = 1'b0,
    MODE_FRAME = 1'b1
  } pol_mode_e;
endpackage

// File: rtl/lcd_pol_cfg.sv
module lcd_pol_cfg
  import lcd_pol_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  localparam int unsigned CFG_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output pol_mode_e        mode_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= {1'b1, {CNT_W{1'b0}}};
    else if (we_i) cfg_q <= wdata_i;
  end

  assign mode_o  = pol_mode_e'(cfg_q[CFG_W-1]);
  assign count_o = cfg_q[CNT_W-1:0];
  assign rdata_o = cfg_q;
endmodule

// File: rtl/lcd_pol_linecnt.sv
module lcd_pol_linecnt
  import lcd_pol_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  localparam int unsigned LIM_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pol_mode_e        mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             line_stb_i,
  input  logic             clr_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] next;
  logic             adv;

  // zero count selects the full range
  assign limit = (count_i == '0) ? (LIM_W'(1) << CNT_W) : {1'b0, count_i};
  assign next  = {1'b0, cnt_q} + LIM_W'(1);
  assign adv   = line_stb_i && (mode_i == MODE_LINE) && !clr_i;
  assign hit_o = adv && (next == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv)   cnt_q <= (next == limit) ? '0 : next[CNT_W-1:0];
  end
endmodule

// File: rtl/lcd_pol_phase.sv
module lcd_pol_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  output logic pol_o,
  output logic flip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o  <= 1'b0;
      flip_o <= 1'b0;
    end else begin
      pol_o  <= pol_o ^ toggle_i;
      flip_o <= toggle_i;
    end
  end
endmodule

// File: rtl/lcd_polarity_gen.sv
module lcd_polarity_gen
  import lcd_pol_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  localparam int unsigned CFG_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_stb_i,
  input  logic             frame_stb_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             pol_o,
  output logic             flip_o
);
  pol_mode_e        mode;
  logic [CNT_W-1:0] count;
  logic             hit;
  logic             toggle;

  lcd_pol_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .mode_o  (mode),
    .count_o (count),
    .rdata_o (cfg_rdata_o)
  );

  lcd_pol_linecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .count_i    (count),
    .line_stb_i (line_stb_i),
    .clr_i      (cfg_we_i),
    .hit_o      (hit)
  );

  // one toggle source per mode, so at most one flip per cycle
  assign toggle = (mode == MODE_FRAME) ? frame_stb_i : hit;

  lcd_pol_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .toggle_i (toggle),
    .pol_o    (pol_o),
    .flip_o   (flip_o)
  );
endmodule

// File: rtl/lcd_pol_chk.sv
module lcd_pol_chk #(
  parameter int unsigned CFG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_stb_i,
  input logic             frame_stb_i,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             pol_o,
  input logic             flip_o
);
  AST_FLIP_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_o != $past(pol_o)) |-> flip_o);  // R8
  AST_CHANGE_ON_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_o |-> (pol_o != $past(pol_o)));  // R8
  AST_FLIP_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_o |-> $past(line_stb_i || frame_stb_i));  // R8
  AST_FRAME_MODE_LINE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_rdata_o[CFG_W-1] && !frame_stb_i) |-> !flip_o);  // R3
  AST_LINE_MODE_FRAME_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cfg_rdata_o[CFG_W-1] && !line_stb_i) |-> !flip_o);  // R6
  AST_WRITE_KEEPS_POL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_we_i && !cfg_rdata_o[CFG_W-1]) |-> (pol_o == $past(pol_o)));  // R7
  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_we_i) |-> (cfg_rdata_o == $past(cfg_wdata_i)));  // R2
endmodule

bind lcd_polarity_gen lcd_pol_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_stb_i  (line_stb_i),
  .frame_stb_i (frame_stb_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .pol_o       (pol_o),
  .flip_o      (flip_o)
);

// File: tb/sim_lcd_polarity_gen.sv
`timescale 1ns/1ps
module sim_lcd_polarity_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0;
  logic       frame_stb = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pol;
  logic       flip;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lcd_polarity_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_stb_i(line_stb), .frame_stb_i(frame_stb),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .pol_o(pol), .flip_o(flip)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe for one cycle; on return the registered result is visible
  task automatic strobe(input logic l, input logic f);
    @(negedge clk); line_stb = l; frame_stb = f;
    @(negedge clk); line_stb = 1'b0; frame_stb = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] v, input logic l);
    @(negedge clk); we = 1'b1; wdata = v; line_stb = l;
    @(negedge clk); we = 1'b0; line_stb = 1'b0;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) strobe(1'b1, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 pol", pol, 0);
    chk("R1 flip", flip, 0);
    chk("R1 cfg", rdata, 8'h80);
  endtask

  task automatic t_frame_mode;
    logic p;
    p = pol;
    lines(5);
    chk("R3 line ignored", pol, p);
    strobe(1'b0, 1'b1);
    chk("R3 frame toggles", pol, !p);
    chk("R8 flip high", flip, 1);
    @(negedge clk);
    chk("R8 flip one cycle", flip, 0);
    strobe(1'b1, 1'b1);
    chk("R3 both strobes one toggle", pol, p);
  endtask

  task automatic t_readback;
    cfg_write(8'h05, 1'b0);
    chk("R2 readback", rdata, 8'h05);
  endtask

  task automatic t_line_mode;
    logic p;
    p = pol;
    lines(4);
    chk("R4 before Nth", pol, p);
    chk("R8 no flip", flip, 0);
    lines(1);
    chk("R4 Nth toggles", pol, !p);
    chk("R8 flip on line", flip, 1);
    p = pol;
    lines(2);
    strobe(1'b0, 1'b1);
    chk("R6 frame ignored", pol, p);
    lines(2);
    chk("R6 counter kept", pol, p);
    lines(1);
    chk("R6 counter not cleared", pol, !p);
  endtask

  task automatic t_write_clear;
    logic p;
    p = pol;
    lines(3);
    cfg_write(8'h05, 1'b0);
    chk("R7 pol kept", pol, p);
    lines(4);
    chk("R7 counter cleared", pol, p);
    lines(1);
    chk("R7 count restarts", pol, !p);
    p = pol;
    cfg_write(8'h03, 1'b1);
    lines(2);
    chk("R7 line with write dropped", pol, p);
    lines(1);
    chk("R7 third line toggles", pol, !p);
    cfg_write(8'h01, 1'b0);
    p = pol;
    strobe(1'b1, 1'b1);
    chk("R6 both strobes one toggle", pol, !p);
  endtask

  task automatic t_zero;
    logic p;
    cfg_write(8'h00, 1'b0);
    p = pol;
    lines(127);
    chk("R5 no toggle at 127", pol, p);
    lines(1);
    chk("R5 toggle at 128", pol, !p);
  endtask

  task automatic t_balance(input logic [6:0] n, input logic expect_same);
    logic [239:0] f0, f1;
    int hi, lo, same;
    cfg_write({1'b0, n}, 1'b0);
    hi = 0; lo = 0; same = 0;
    for (int fr = 0; fr < 2; fr++)
      for (int ln = 0; ln < 240; ln++) begin
        if (fr == 0) f0[ln] = pol; else f1[ln] = pol;
        if (pol) hi++; else lo++;
        strobe(1'b1, ln == 0);
      end
    for (int ln = 0; ln < 240; ln++) if (f0[ln] == f1[ln]) same++;
    if (expect_same) chk("R9 N=8 pattern repeats", same, 240);
    else begin
      chk("R9 N=16 pattern alternates", same, 0);
      chk("R9 N=16 balance", hi, lo);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame_mode();
    t_readback();
    t_line_mode();
    t_write_clear();
    t_zero();
    t_balance(7'd16, 1'b0);
    t_balance(7'd8, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule